// File: doc/BRIEF.md
# Interrupt Destination Mask Generator

This block takes one interrupt request and works out which of `N_AGENTS` agents receive it. It returns the result as a bitmask. A request comes in one of two forms. The direct form supplies a destination byte, a physical/logical mode flag, a shorthand code, a sender index, a delivery mode, a vector and level/trigger bits. The message form supplies a 32-bit address and a 32-bit data word from a message-signalled write, and the block extracts the same fields from them.

Each agent holds a small configuration set, written through a plain configuration port:
- a physical ID;
- a logical destination byte;
- a model nibble, either flat (0xF) or cluster (0x0).

In lowest-priority delivery the mask is reduced to a single target. An INIT de-assert message produces no output. Instead, it copies each target's physical ID into that target's arbitration ID, and the arbitration IDs are visible on a port.

Requests enter on a valid/ready handshake. The result leaves on a second valid/ready handshake from a single output register:
- `req_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, every output field is held.

Top module: `idm_dest_gen`

## Requirements
- R1: In physical mode (logical flag 0), destination 0xFF selects every agent. Any other destination selects only the lowest-indexed agent whose physical ID equals it, or no agent when none matches.
- R2: In logical mode, an agent with model nibble 0xF matches when the bitwise AND of the destination and its logical byte is nonzero.
- R3: In logical mode, an agent with model nibble 0x0 matches when two conditions both hold: the destination's upper nibble equals the upper nibble of its logical byte, and the two lower nibbles share at least one set bit. An agent with any other model value never matches in logical mode.
- R4: The direct-form shorthand selects the agents as follows: 0 uses the destination decode, 1 selects only the sender, 2 selects all agents, and 3 selects all agents except the sender.
- R5: Delivery mode 1 (lowest priority) reduces the computed mask to its lowest-indexed set bit.
- R6: Mask bits at or above `N_AGENTS` are always 0. A sender index at or above `N_AGENTS` selects no agent for shorthand 1 and removes no agent for shorthand 3.
- R7: In message form, the fields are taken from these bit positions, and the shorthand is treated as 0:

  | Field | Source bits |
  |---|---|
  | destination | address bits 19:12 |
  | logical flag | address bit 2 |
  | vector | data bits 7:0 |
  | delivery mode | data bits 10:8 |
  | level | data bit 14 |
  | trigger | data bit 15 |

- R8: An accepted request with delivery mode 5 (INIT), level 0 and trigger 1 produces no output. In the same cycle it loads each masked agent's arbitration ID with that agent's physical ID. An INIT with level 1 is output like any other request.
- R9: An accepted request appears on the outputs with `out_valid` one clock later. `req_ready` equals `!out_valid || out_ready`. The outputs stay unchanged while `out_valid && !out_ready`.
- R10: After reset, the block is in this state:
  - `out_valid` is 0;
  - agent i has physical ID i, logical byte 0 and model 0xF;
  - every arbitration ID is 0.
- R11: `out_sideband` is 1 exactly for delivery modes 2, 4 and 5 (SMI, NMI, INIT) and 0 for modes 0, 1, 6 and 7 (fixed, lowest, startup, external). `out_dmode`, `out_vector` and `out_trig` carry the request's values.
- R12: Configuration writes select the field with `cfg_field`: 0 for the physical ID, 1 for the logical byte, 2 for the model (low nibble of the data). Writes with `cfg_field` 3, or with `cfg_agent` at or above `N_AGENTS`, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_agent | input | 8 | Agent index for the configuration write |
| cfg_field | input | 2 | 0 physical ID, 1 logical byte, 2 model, 3 none |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_msg | input | 1 | 1: decode fields from req_addr/req_data |
| req_addr | input | 32 | Message address |
| req_data | input | 32 | Message data |
| req_dest | input | 8 | Direct-form destination |
| req_logical | input | 1 | Direct-form logical destination flag |
| req_shorthand | input | 2 | Direct-form shorthand code |
| req_src | input | 8 | Sender agent index |
| req_dmode | input | 3 | Direct-form delivery mode |
| req_vector | input | 8 | Direct-form vector |
| req_level | input | 1 | Direct-form level bit |
| req_trig | input | 1 | Direct-form trigger bit |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed when high with out_valid |
| out_mask | output | MASK_W | Target agents, bit i for agent i |
| out_dmode | output | 3 | Delivery mode of the result |
| out_vector | output | 8 | Vector of the result |
| out_trig | output | 1 | Trigger bit of the result |
| out_sideband | output | 1 | Result is SMI, NMI or INIT |
| arb_ids | output | 8*N_AGENTS | Arbitration ID of agent i at bits 8i+7:8i |

## Verification
The bench builds the block with `N_AGENTS` = 6 and `MASK_W` = 8, which leaves two mask bits above the last agent. With that setup:
- Broadcast and all-agents shorthands can be shown to leave bits 6 and 7 clear.
- A sender index of 7 exercises the out-of-range sender case.

The six agents are configured to cover both logical models and an unrecognised model value. Two of them share a physical ID, which tests the lowest-index tie rule in physical mode.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int ID_W = 8;

  // Delivery-mode codes (3-bit field)
  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWEST = 3'd1;
  localparam logic [2:0] DM_SMI    = 3'd2;
  localparam logic [2:0] DM_NMI    = 3'd4;
  localparam logic [2:0] DM_INIT   = 3'd5;
  localparam logic [2:0] DM_START  = 3'd6;
  localparam logic [2:0] DM_EXT    = 3'd7;

  // Logical model nibbles
  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;

  // Configuration field selectors
  localparam logic [1:0] CFG_PHYS  = 2'd0;
  localparam logic [1:0] CFG_LOGIC = 2'd1;
  localparam logic [1:0] CFG_MODEL = 2'd2;

  // Shorthand codes
  localparam logic [1:0] SH_DEST   = 2'd0;
  localparam logic [1:0] SH_SELF   = 2'd1;
  localparam logic [1:0] SH_ALL    = 2'd2;
  localparam logic [1:0] SH_OTHERS = 2'd3;

  localparam logic [ID_W-1:0] BCAST_ID = 8'hFF;

  typedef struct packed {
    logic [ID_W-1:0] dest;
    logic            logical;
    logic [1:0]      shorthand;
    logic [2:0]      dmode;
    logic [7:0]      vector;
    logic            level;
    logic            trig;
  } req_fields_t;
endpackage

// File: rtl/idm_lowest_pick.sv
module idm_lowest_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec_in,
  output logic [W-1:0] first_out
);
  // Isolate the lowest set bit: x & -x
  assign first_out = vec_in & (~vec_in + W'(1));
endmodule

// File: rtl/idm_cfg_regs.sv
module idm_cfg_regs
  import idm_pkg::*;
#(
  parameter int N_AGENTS = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [7:0]                     cfg_agent,
  input  logic [1:0]                     cfg_field,
  input  logic [7:0]                     cfg_wdata,
  input  logic [N_AGENTS-1:0]            arb_load,
  output logic [N_AGENTS-1:0][ID_W-1:0]  phys_id,
  output logic [N_AGENTS-1:0][ID_W-1:0]  log_id,
  output logic [N_AGENTS-1:0][3:0]       model,
  output logic [N_AGENTS-1:0][ID_W-1:0]  arb_id
);
  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    logic hit;
    assign hit = cfg_we && (cfg_agent == 8'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phys_id[g] <= ID_W'(g);
        log_id[g]  <= '0;
        model[g]   <= MODEL_FLAT;
        arb_id[g]  <= '0;
      end else begin
        if (hit) begin
          case (cfg_field)
            CFG_PHYS:  phys_id[g] <= cfg_wdata;
            CFG_LOGIC: log_id[g]  <= cfg_wdata;
            CFG_MODEL: model[g]   <= cfg_wdata[3:0];
            default:   ;
          endcase
        end
        if (arb_load[g]) arb_id[g] <= phys_id[g];
      end
    end
  end
endmodule

// File: rtl/idm_agent_match.sv
module idm_agent_match
  import idm_pkg::*;
#(
  parameter int N_AGENTS = 6
) (
  input  logic [ID_W-1:0]                dest,
  input  logic [N_AGENTS-1:0][ID_W-1:0]  phys_id,
  input  logic [N_AGENTS-1:0][ID_W-1:0]  log_id,
  input  logic [N_AGENTS-1:0][3:0]       model,
  output logic [N_AGENTS-1:0]            phys_eq,
  output logic [N_AGENTS-1:0]            logic_hit
);
  for (genvar g = 0; g < N_AGENTS; g++) begin : g_match
    logic flat_hit, clus_hit;
    assign phys_eq[g] = (phys_id[g] == dest);
    assign flat_hit   = |(dest & log_id[g]);
    assign clus_hit   = (dest[7:4] == log_id[g][7:4]) && |(dest[3:0] & log_id[g][3:0]);
    always_comb begin
      case (model[g])
        MODEL_FLAT:    logic_hit[g] = flat_hit;
        MODEL_CLUSTER: logic_hit[g] = clus_hit;
        default:       logic_hit[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/idm_dest_gen.sv
module idm_dest_gen
  import idm_pkg::*;
#(
  parameter int N_AGENTS = 6,
  parameter int MASK_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [7:0]                 cfg_agent,
  input  logic [1:0]                 cfg_field,
  input  logic [7:0]                 cfg_wdata,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_msg,
  input  logic [31:0]                req_addr,
  input  logic [31:0]                req_data,
  input  logic [7:0]                 req_dest,
  input  logic                       req_logical,
  input  logic [1:0]                 req_shorthand,
  input  logic [7:0]                 req_src,
  input  logic [2:0]                 req_dmode,
  input  logic [7:0]                 req_vector,
  input  logic                       req_level,
  input  logic                       req_trig,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [MASK_W-1:0]          out_mask,
  output logic [2:0]                 out_dmode,
  output logic [7:0]                 out_vector,
  output logic                       out_trig,
  output logic                       out_sideband,
  output logic [8*N_AGENTS-1:0]      arb_ids
);
  localparam int N = N_AGENTS;

  logic [N-1:0][ID_W-1:0] phys_id, log_id, arb_id;
  logic [N-1:0][3:0]      model;
  logic [N-1:0]           arb_load;
  logic [N-1:0]           phys_eq, logic_hit, phys_first;
  logic [N-1:0]           self_m, dest_m, sh_m, lowest_m, final_m;
  req_fields_t            f;
  logic                   accept, init_deassert, is_sideband;

  // Field extraction: message form or direct form
  always_comb begin
    if (req_msg) begin
      f.dest      = req_addr[19:12];
      f.logical   = req_addr[2];
      f.shorthand = SH_DEST;
      f.vector    = req_data[7:0];
      f.dmode     = req_data[10:8];
      f.level     = req_data[14];
      f.trig      = req_data[15];
    end else begin
      f.dest      = req_dest;
      f.logical   = req_logical;
      f.shorthand = req_shorthand;
      f.vector    = req_vector;
      f.dmode     = req_dmode;
      f.level     = req_level;
      f.trig      = req_trig;
    end
  end

  idm_cfg_regs #(.N_AGENTS(N)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_agent(cfg_agent),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .arb_load(arb_load),
    .phys_id(phys_id), .log_id(log_id), .model(model), .arb_id(arb_id)
  );

  idm_agent_match #(.N_AGENTS(N)) u_match (
    .dest(f.dest), .phys_id(phys_id), .log_id(log_id), .model(model),
    .phys_eq(phys_eq), .logic_hit(logic_hit)
  );

  idm_lowest_pick #(.W(N)) u_phys_pick (.vec_in(phys_eq), .first_out(phys_first));

  for (genvar g = 0; g < N; g++) begin : g_self
    assign self_m[g] = (req_src == 8'(g));
    assign arb_ids[8*g +: 8] = arb_id[g];
  end

  always_comb begin
    if (f.logical)                dest_m = logic_hit;
    else if (f.dest == BCAST_ID)  dest_m = '1;
    else                          dest_m = phys_first;
  end

  always_comb begin
    case (f.shorthand)
      SH_SELF:   sh_m = self_m;
      SH_ALL:    sh_m = '1;
      SH_OTHERS: sh_m = ~self_m;
      default:   sh_m = dest_m;
    endcase
  end

  idm_lowest_pick #(.W(N)) u_low_pick (.vec_in(sh_m), .first_out(lowest_m));

  assign final_m       = (f.dmode == DM_LOWEST) ? lowest_m : sh_m;
  assign init_deassert = (f.dmode == DM_INIT) && !f.level && f.trig;
  assign is_sideband   = (f.dmode == DM_SMI) || (f.dmode == DM_NMI) || (f.dmode == DM_INIT);
  assign req_ready     = !out_valid || out_ready;
  assign accept        = req_valid && req_ready;
  assign arb_load      = (accept && init_deassert) ? final_m : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_mask     <= '0;
      out_dmode    <= DM_FIXED;
      out_vector   <= '0;
      out_trig     <= 1'b0;
      out_sideband <= 1'b0;
    end else if (accept && !init_deassert) begin
      out_valid    <= 1'b1;
      out_mask     <= MASK_W'(final_m);
      out_dmode    <= f.dmode;
      out_vector   <= f.vector;
      out_trig     <= f.trig;
      out_sideband <= is_sideband;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/idm_dest_chk.sv
module idm_dest_chk #(
  parameter int N_AGENTS = 6,
  parameter int MASK_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [MASK_W-1:0] out_mask,
  input logic [2:0]        out_dmode,
  input logic [7:0]        out_vector,
  input logic              out_sideband
);
  logic [MASK_W-1:0] upper_bits;
  always_comb begin
    for (int i = 0; i < MASK_W; i++) upper_bits[i] = (i >= N_AGENTS);
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mask) && $stable(out_dmode) && $stable(out_vector)); // R9
  AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(req_valid)); // R9
  AST_NO_UPPER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask & upper_bits) == '0); // R6
  AST_LOWEST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dmode == 3'd1 |-> $onehot0(out_mask)); // R5
  AST_SIDEBAND_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sideband == (out_dmode == 3'd2 || out_dmode == 3'd4 || out_dmode == 3'd5)); // R11
endmodule

bind idm_dest_gen idm_dest_chk #(.N_AGENTS(N_AGENTS), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_mask(out_mask), .out_dmode(out_dmode),
  .out_vector(out_vector), .out_sideband(out_sideband)
);

// File: tb/tb_idm_dest_gen.sv
module tb_idm_dest_gen;
  localparam int N = 6;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0; logic [7:0] cfg_agent = 0; logic [1:0] cfg_field = 0; logic [7:0] cfg_wdata = 0;
  logic req_valid = 0, req_ready, req_msg = 0;
  logic [31:0] req_addr = 0, req_data = 0;
  logic [7:0] req_dest = 0, req_src = 0, req_vector = 0;
  logic req_logical = 0, req_level = 1, req_trig = 0;
  logic [1:0] req_shorthand = 0;
  logic [2:0] req_dmode = 0;
  logic out_valid, out_ready = 1, out_trig, out_sideband;
  logic [MW-1:0] out_mask;
  logic [2:0] out_dmode;
  logic [7:0] out_vector;
  logic [8*N-1:0] arb_ids;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  idm_dest_gen #(.N_AGENTS(N), .MASK_W(MW)) dut (.*);

  typedef struct packed {
    logic       msg;
    logic [7:0] dest;
    logic       lg;
    logic [1:0] sh;
    logic [7:0] src;
    logic [2:0] dm;
    logic [7:0] vec;
    logic       trig;
    logic [7:0] emask;
    logic       esb;
  } vec_t;

  // Agents: 0 phys10 log01 flat, 1 phys11 log02 flat, 2 phys12 log04 flat,
  // 3 phys11 log21 cluster, 4 phys14 log22 cluster, 5 phys15 log31 model5
  localparam vec_t TBL [16] = '{
    '{1'b0, 8'hFF, 1'b0, 2'd0, 8'd0, 3'd0, 8'h20, 1'b0, 8'h3F, 1'b0}, // R1 broadcast
    '{1'b0, 8'h11, 1'b0, 2'd0, 8'd0, 3'd0, 8'h21, 1'b1, 8'h02, 1'b0}, // R1 lowest dup
    '{1'b0, 8'h99, 1'b0, 2'd0, 8'd0, 3'd0, 8'h22, 1'b0, 8'h00, 1'b0}, // R1 no match
    '{1'b0, 8'h05, 1'b1, 2'd0, 8'd0, 3'd0, 8'h23, 1'b0, 8'h05, 1'b0}, // R2 flat
    '{1'b0, 8'h23, 1'b1, 2'd0, 8'd0, 3'd0, 8'h24, 1'b0, 8'h1B, 1'b0}, // R2 R3 mixed
    '{1'b0, 8'h31, 1'b1, 2'd0, 8'd0, 3'd0, 8'h25, 1'b0, 8'h01, 1'b0}, // R3 bad model
    '{1'b0, 8'h24, 1'b1, 2'd0, 8'd0, 3'd0, 8'h26, 1'b0, 8'h04, 1'b0}, // R3 no lower bit
    '{1'b0, 8'h00, 1'b0, 2'd1, 8'd3, 3'd0, 8'h27, 1'b0, 8'h08, 1'b0}, // R4 self
    '{1'b0, 8'h00, 1'b0, 2'd2, 8'd3, 3'd0, 8'h28, 1'b0, 8'h3F, 1'b0}, // R4 all
    '{1'b0, 8'h00, 1'b0, 2'd3, 8'd3, 3'd0, 8'h29, 1'b0, 8'h37, 1'b0}, // R4 others
    '{1'b0, 8'h00, 1'b0, 2'd3, 8'd7, 3'd0, 8'h2A, 1'b0, 8'h3F, 1'b0}, // R6 others, src out of range
    '{1'b0, 8'h00, 1'b0, 2'd1, 8'd7, 3'd0, 8'h2B, 1'b0, 8'h00, 1'b0}, // R6 self, src out of range
    '{1'b0, 8'h00, 1'b0, 2'd3, 8'd0, 3'd1, 8'h2C, 1'b0, 8'h02, 1'b0}, // R5 lowest
    '{1'b1, 8'h12, 1'b0, 2'd0, 8'd0, 3'd0, 8'h41, 1'b1, 8'h04, 1'b0}, // R7 msg physical
    '{1'b1, 8'h23, 1'b1, 2'd0, 8'd0, 3'd6, 8'h42, 1'b0, 8'h1B, 1'b0}, // R7 msg logical startup
    '{1'b0, 8'hFF, 1'b0, 2'd0, 8'd0, 3'd4, 8'h00, 1'b0, 8'h3F, 1'b1}  // R11 NMI
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int a, input int fld, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_agent = 8'(a); cfg_field = 2'(fld); cfg_wdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Drive one request for one cycle; return at the following negedge
  task automatic send(input vec_t v, input logic lvl);
    @(negedge clk);
    req_msg = v.msg;
    if (v.msg) begin
      req_addr = {12'hFEE, v.dest, 9'd0, v.lg, 2'd0};
      req_data = {16'd0, v.trig, lvl, 3'd0, v.dm, v.vec};
      req_dest = 8'hFF; req_logical = 0; req_shorthand = 2'd2; req_dmode = 3'd4;
      req_vector = 8'h00; req_trig = ~v.trig; req_level = ~lvl;
    end else begin
      req_dest = v.dest; req_logical = v.lg; req_shorthand = v.sh; req_src = v.src;
      req_dmode = v.dm; req_vector = v.vec; req_trig = v.trig; req_level = lvl;
      req_addr = 32'hFFFF_FFFF; req_data = 32'hFFFF_FFFF;
    end
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", out_valid, 0);
    chk("R10 arb_ids", arb_ids, '0);
    chk("R9 ready when empty", req_ready, 1);
    rst_n = 1;
    // R10 default physical ID equals index
    v = '{1'b0, 8'h02, 1'b0, 2'd0, 8'd0, 3'd0, 8'h10, 1'b0, 8'h04, 1'b0};
    send(v, 1'b1);
    chk("R10 default phys id", out_mask, 8'h04);
    // R10 default flat model with logical byte 0: logical never matches
    v = '{1'b0, 8'hFF, 1'b1, 2'd0, 8'd0, 3'd0, 8'h10, 1'b0, 8'h00, 1'b0};
    send(v, 1'b1);
    chk("R10 default logical zero", out_mask, 8'h00);

    // Configure agents
    cfg(0, 0, 8'h10); cfg(0, 1, 8'h01);
    cfg(1, 0, 8'h11); cfg(1, 1, 8'h02);
    cfg(2, 0, 8'h12); cfg(2, 1, 8'h04);
    cfg(3, 0, 8'h11); cfg(3, 1, 8'h21); cfg(3, 2, 8'h00);
    cfg(4, 0, 8'h14); cfg(4, 1, 8'h22); cfg(4, 2, 8'hF0);
    cfg(5, 0, 8'h15); cfg(5, 1, 8'h31); cfg(5, 2, 8'h05);
    // R12 ignored writes: field 3 and agent out of range
    cfg(2, 3, 8'h77);
    cfg(6, 0, 8'h12);
    v = '{1'b0, 8'h12, 1'b0, 2'd0, 8'd0, 3'd0, 8'h10, 1'b0, 8'h04, 1'b0};
    send(v, 1'b1);
    chk("R12 ignored writes", out_mask, 8'h04);

    // Table walk
    for (int i = 0; i < 16; i++) begin
      send(TBL[i], 1'b1);
      chk($sformatf("R1-table[%0d] valid", i), out_valid, 1);
      chk($sformatf("mask[%0d] R1 R2 R3 R4 R5 R6 R7", i), out_mask, TBL[i].emask);
      chk($sformatf("R11 vec[%0d]", i), out_vector, TBL[i].vec);
      chk($sformatf("R11 dmode[%0d]", i), out_dmode, TBL[i].dm);
      chk($sformatf("R11 trig[%0d]", i), out_trig, TBL[i].trig);
      chk($sformatf("R11 sideband[%0d]", i), out_sideband, TBL[i].esb);
    end

    // R8 INIT de-assert: all-but-self from sender 1, no output
    v = '{1'b0, 8'h00, 1'b0, 2'd3, 8'd1, 3'd5, 8'h00, 1'b1, 8'h00, 1'b0};
    send(v, 1'b0);
    chk("R8 no output", out_valid, 0);
    chk("R8 arb ids", arb_ids, {8'h15, 8'h14, 8'h11, 8'h12, 8'h00, 8'h10});
    // R8 INIT with level 1 emits
    send(v, 1'b1);
    chk("R8 init assert emits", out_valid, 1);
    chk("R8 init assert mask", out_mask, 8'h3D);
    chk("R11 init sideband", out_sideband, 1);

    // R9 back-pressure
    @(negedge clk);
    out_ready = 0;
    v = '{1'b0, 8'h10, 1'b0, 2'd0, 8'd0, 3'd0, 8'h55, 1'b0, 8'h01, 1'b0};
    send(v, 1'b1);
    chk("R9 first held", out_mask, 8'h01);
    chk("R9 ready low", req_ready, 0);
    v = '{1'b0, 8'h14, 1'b0, 2'd0, 8'd0, 3'd0, 8'h66, 1'b0, 8'h10, 1'b0};
    send(v, 1'b1);
    chk("R9 stalled mask", out_mask, 8'h01);
    chk("R9 stalled vector", out_vector, 8'h55);
    chk("R9 stalled valid", out_valid, 1);
    out_ready = 1;
    send(v, 1'b1);
    chk("R9 drained next", out_mask, 8'h10);
    chk("R9 drained vector", out_vector, 8'h66);
    @(posedge clk);
    @(negedge clk);
    chk("R9 empties", out_valid, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule